// File: doc/BRIEF.md
# Calendar Alarm Comparator and Interrupt Driver

This block watches the calendar time of a real-time clock and raises an interrupt when it matches a programmed alarm. Time arrives as seven parallel BCD fields, eight bits each, packed into one vector. A strobe that is high for one cycle per second marks a new time value. The alarm value uses the same packing. Each field has its own enable bit, so any combination of fields can take part in the match.

The alarm has two modes on one active-low interrupt pin. In latched mode a match pulls the pin low and holds it there until the sticky status flag is cleared. In recurring mode every match drives a low pulse whose length is counted in millisecond ticks (250 by default), and it also sets the flag. The flag is cleared by a software clear strobe, or by a status read when auto-clear is selected. The alarm is silenced while the shared pin is in use as a frequency output, and also during battery backup unless backup operation is allowed.

Top module: `alarm_irq_unit`

## Requirements
- R1: After reset `irq_n` is 1 and `alarm_flag` is 0.
- R2: Field i sits in bits [8*i+7:8*i] of `now_bcd` and `alm_bcd`, with enable bit `field_en[i]`. The order is i=0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 year, 6 weekday. A match needs every enabled field to be equal. A field whose enable is off is ignored.
- R3: When `field_en` is all zeros, no match ever occurs.
- R4: The match is sampled only on a cycle where `sec_tick` is 1. A matching time without a tick sets nothing.
- R5: With `alarm_en` at 0, a match sets no flag and `irq_n` stays 1.
- R6: Latched mode (`pulse_mode`=0): a match on the tick cycle sets `alarm_flag` and drives `irq_n` low from the next clock edge. Both hold until the flag is cleared.
- R7: Recurring mode (`pulse_mode`=1): a match sets the flag and holds `irq_n` low for exactly PULSE_MS `ms_tick` pulses. A new match during a pulse restarts the count.
- R8: `status_clr` clears the flag at the next edge. In latched mode this releases `irq_n`.
- R9: `status_rd` clears the flag only when `auto_clr` is 1. When `auto_clr` is 0, a read has no effect.
- R10: While `fout_en` is 1, matches set nothing and `irq_n` stays 1, even if the flag is already set.
- R11: While `on_backup` is 1 and `backup_alarm_en` is 0, the alarm is suppressed. With `backup_alarm_en` set to 1, it works.
- R12: If a match and a clear happen in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-cycle strobe per second; the match is sampled here |
| ms_tick | input | 1 | One-cycle strobe per millisecond; times the pulse |
| now_bcd | input | 56 | Current time, seven packed BCD fields |
| alm_bcd | input | 56 | Alarm time, same packing |
| field_en | input | 7 | Per-field compare enable |
| alarm_en | input | 1 | Master alarm enable |
| pulse_mode | input | 1 | 0 latched, 1 recurring pulse |
| fout_en | input | 1 | Pin used as frequency output; alarm off |
| auto_clr | input | 1 | Status read clears the flag |
| on_backup | input | 1 | Device running from backup supply |
| backup_alarm_en | input | 1 | Allow the alarm while on backup |
| status_rd | input | 1 | Status register read strobe |
| status_clr | input | 1 | Software clear of the flag |
| irq_n | output | 1 | Active-low interrupt |
| alarm_flag | output | 1 | Sticky alarm status |

## Verification
A flag that sticks or drops wrongly shows at the ports one edge later. In latched mode it also shows on `irq_n`, because the pin follows the flag. A bad pulse counter shows only at the end of a pulse, up to PULSE_MS millisecond ticks after the match. For that reason the pin is sampled one tick before and one tick after the expected release, and also after a retrigger. A wrong gating term shows as a flag set while the alarm should be suppressed.

// File: rtl/alm_pkg.sv
package alm_pkg;
    localparam int NUM_FIELDS = 7;
    localparam int FIELD_W    = 8;
    localparam int TIME_W     = NUM_FIELDS * FIELD_W;

    typedef enum logic [2:0] {
        F_SEC   = 3'd0,
        F_MIN   = 3'd1,
        F_HOUR  = 3'd2,
        F_DATE  = 3'd3,
        F_MONTH = 3'd4,
        F_YEAR  = 3'd5,
        F_WDAY  = 3'd6
    } field_idx_e;

    typedef struct packed {
        logic enable;
        logic recurring;
        logic pin_is_fout;
        logic clear_on_read;
        logic on_backup;
        logic backup_allowed;
    } alm_ctrl_t;

    function automatic logic alarm_live(input alm_ctrl_t c);
        return c.enable && !c.pin_is_fout && (!c.on_backup || c.backup_allowed);
    endfunction
endpackage

// File: rtl/alm_match.sv
module alm_match
    import alm_pkg::*;
#(
    parameter int NF = NUM_FIELDS,
    parameter int FW = FIELD_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NF*FW-1:0] now_bcd,
    input  logic [NF*FW-1:0] alm_bcd,
    input  logic [NF-1:0]    field_en,
    output logic             hit
);
    logic [NF-1:0] field_ok;

    for (genvar i = 0; i < NF; i++) begin : g_cmp
        assign field_ok[i] = !field_en[i] ||
                             (now_bcd[i*FW +: FW] == alm_bcd[i*FW +: FW]);
    end

    assign hit = (&field_ok) && (|field_en);

    // R3: a hit always has at least one field taking part
    assert_hit_needs_field_R3: assert property (@(posedge clk) disable iff (rst)
        hit |-> (field_en != '0));
endmodule

// File: rtl/alm_pulse_timer.sv
module alm_pulse_timer #(
    parameter int PULSE_MS = 250
) (
    input  logic clk,
    input  logic rst,
    input  logic kill,
    input  logic load,
    input  logic ms_tick,
    output logic busy
);
    localparam int CW = $clog2(PULSE_MS + 1);
    localparam logic [CW-1:0] FULL = CW'(PULSE_MS);

    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst || kill)
            remain <= '0;
        else if (load)
            remain <= FULL;
        else if (ms_tick && remain != '0)
            remain <= remain - 1'b1;
    end

    assign busy = (remain != '0);

    assert_load_full_R7: assert property (@(posedge clk) disable iff (rst)
        (load && !kill) |=> (remain == FULL));
    assert_no_overrun_R7: assert property (@(posedge clk) disable iff (rst)
        remain <= FULL);
    assert_hold_without_tick_R7: assert property (@(posedge clk) disable iff (rst)
        (!load && !ms_tick && !kill) |=> $stable(remain));
endmodule

// File: rtl/alm_status.sv
module alm_status (
    input  logic clk,
    input  logic rst,
    input  logic set_req,
    input  logic clr_req,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else if (set_req)
            flag <= 1'b1;
        else if (clr_req)
            flag <= 1'b0;
    end

    assert_set_wins_R12: assert property (@(posedge clk) disable iff (rst)
        set_req |=> flag);
    assert_clear_takes_R8: assert property (@(posedge clk) disable iff (rst)
        (clr_req && !set_req) |=> !flag);
    assert_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr_req) |=> flag);
endmodule

// File: rtl/alarm_irq_unit.sv
module alarm_irq_unit
    import alm_pkg::*;
#(
    parameter int PULSE_MS = 250
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sec_tick,
    input  logic              ms_tick,
    input  logic [TIME_W-1:0] now_bcd,
    input  logic [TIME_W-1:0] alm_bcd,
    input  logic [NUM_FIELDS-1:0] field_en,
    input  logic              alarm_en,
    input  logic              pulse_mode,
    input  logic              fout_en,
    input  logic              auto_clr,
    input  logic              on_backup,
    input  logic              backup_alarm_en,
    input  logic              status_rd,
    input  logic              status_clr,
    output logic              irq_n,
    output logic              alarm_flag
);
    alm_ctrl_t ctrl;
    logic      live, hit, fire, pulse_busy, clr_req, drive_low;

    always_comb begin
        ctrl.enable         = alarm_en;
        ctrl.recurring      = pulse_mode;
        ctrl.pin_is_fout    = fout_en;
        ctrl.clear_on_read  = auto_clr;
        ctrl.on_backup      = on_backup;
        ctrl.backup_allowed = backup_alarm_en;
    end

    assign live    = alarm_live(ctrl);
    assign clr_req = status_clr || (ctrl.clear_on_read && status_rd);

    alm_match #(.NF(NUM_FIELDS), .FW(FIELD_W)) u_match (
        .clk(clk), .rst(rst),
        .now_bcd(now_bcd), .alm_bcd(alm_bcd), .field_en(field_en),
        .hit(hit)
    );

    assign fire = sec_tick && live && hit;

    alm_status u_status (
        .clk(clk), .rst(rst),
        .set_req(fire), .clr_req(clr_req),
        .flag(alarm_flag)
    );

    alm_pulse_timer #(.PULSE_MS(PULSE_MS)) u_pulse (
        .clk(clk), .rst(rst),
        .kill(!live),
        .load(fire && ctrl.recurring),
        .ms_tick(ms_tick),
        .busy(pulse_busy)
    );

    always_comb begin
        if (!live)
            drive_low = 1'b0;
        else if (ctrl.recurring)
            drive_low = pulse_busy;
        else
            drive_low = alarm_flag;
    end

    assign irq_n = !drive_low;

    assert_fout_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        fout_en |-> irq_n);
    assert_no_fire_when_off_R5: assert property (@(posedge clk) disable iff (rst)
        (!alarm_en && !alarm_flag && !status_rd && !status_clr) |=> !alarm_flag);
    assert_latched_pin_R6: assert property (@(posedge clk) disable iff (rst)
        (fire && !pulse_mode) |=> (!irq_n || !live));
endmodule

// File: tb/sim_alarm_irq_unit.sv
module sim_alarm_irq_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        sec_tick, ms_tick;
    logic [55:0] now_bcd, alm_bcd;
    logic [6:0]  field_en;
    logic        alarm_en, pulse_mode, fout_en, auto_clr;
    logic        on_backup, backup_alarm_en, status_rd, status_clr;
    logic        irq_n, alarm_flag;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    alarm_irq_unit u0 (
        .clk(clk), .rst(rst), .sec_tick(sec_tick), .ms_tick(ms_tick),
        .now_bcd(now_bcd), .alm_bcd(alm_bcd), .field_en(field_en),
        .alarm_en(alarm_en), .pulse_mode(pulse_mode), .fout_en(fout_en),
        .auto_clr(auto_clr), .on_backup(on_backup),
        .backup_alarm_en(backup_alarm_en), .status_rd(status_rd),
        .status_clr(status_clr), .irq_n(irq_n), .alarm_flag(alarm_flag)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic set_field(input int idx, input logic [7:0] nowv, input logic [7:0] almv);
        now_bcd[idx*8 +: 8] = nowv;
        alm_bcd[idx*8 +: 8] = almv;
    endtask

    task automatic pulse_sec();
        sec_tick = 1'b1; @(negedge clk); sec_tick = 1'b0;
    endtask

    task automatic ms_ticks(input int n);
        for (int k = 0; k < n; k++) begin
            ms_tick = 1'b1; @(negedge clk); ms_tick = 1'b0; @(negedge clk);
        end
    endtask

    task automatic sw_clear();
        status_clr = 1'b1; @(negedge clk); status_clr = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 irq_n", irq_n, 1'b1);
        check("R1 flag", alarm_flag, 1'b0);
    endtask

    task automatic t_single();
        set_field(0, 8'h30, 8'h30);
        field_en = 7'b000_0001;
        repeat (3) @(negedge clk);
        check("R4 no tick flag", alarm_flag, 1'b0);
        pulse_sec();
        check("R6 flag set", alarm_flag, 1'b1);
        check("R6 irq low", irq_n, 1'b0);
        repeat (5) @(negedge clk);
        check("R6 irq held", irq_n, 1'b0);
        sw_clear();
        check("R8 flag cleared", alarm_flag, 1'b0);
        check("R8 irq released", irq_n, 1'b1);
    endtask

    task automatic t_fields();
        set_field(1, 8'h15, 8'h16);
        field_en = 7'b000_0011;
        pulse_sec();
        check("R2 minute mismatch", alarm_flag, 1'b0);
        set_field(1, 8'h16, 8'h16);
        set_field(2, 8'h09, 8'h21);
        pulse_sec();
        check("R2 hour disabled ignored", alarm_flag, 1'b1);
        sw_clear();
        set_field(4, 8'h12, 8'h12);
        set_field(0, 8'h00, 8'h59);
        field_en = 7'b001_0000;
        pulse_sec();
        check("R2 month only match", alarm_flag, 1'b1);
        sw_clear();
        field_en = 7'b000_0000;
        pulse_sec();
        check("R3 no field enabled", alarm_flag, 1'b0);
        field_en = 7'b001_0000;
    endtask

    task automatic t_disabled();
        alarm_en = 1'b0;
        pulse_sec();
        check("R5 flag stays clear", alarm_flag, 1'b0);
        check("R5 irq high", irq_n, 1'b1);
        alarm_en = 1'b1;
    endtask

    task automatic t_pulse();
        pulse_mode = 1'b1;
        pulse_sec();
        check("R7 flag set", alarm_flag, 1'b1);
        check("R7 irq low", irq_n, 1'b0);
        ms_ticks(249);
        check("R7 low before end", irq_n, 1'b0);
        ms_ticks(1);
        check("R7 released at end", irq_n, 1'b1);
        check("R7 flag still set", alarm_flag, 1'b1);
        sw_clear();
        pulse_sec();
        ms_ticks(100);
        pulse_sec();
        ms_ticks(249);
        check("R7 retrigger restarts", irq_n, 1'b0);
        ms_ticks(1);
        check("R7 retrigger release", irq_n, 1'b1);
        sw_clear();
        pulse_mode = 1'b0;
    endtask

    task automatic t_autoclr();
        pulse_sec();
        auto_clr = 1'b0;
        status_rd = 1'b1; @(negedge clk); status_rd = 1'b0;
        check("R9 read ignored without auto", alarm_flag, 1'b1);
        auto_clr = 1'b1;
        status_rd = 1'b1; @(negedge clk); status_rd = 1'b0;
        check("R9 read clears with auto", alarm_flag, 1'b0);
        check("R9 irq released", irq_n, 1'b1);
        auto_clr = 1'b0;
    endtask

    task automatic t_fout();
        fout_en = 1'b1;
        pulse_sec();
        check("R10 no flag with fout", alarm_flag, 1'b0);
        check("R10 irq high with fout", irq_n, 1'b1);
        fout_en = 1'b0;
        pulse_sec();
        fout_en = 1'b1;
        @(negedge clk);
        check("R10 set flag does not drive pin", irq_n, 1'b1);
        fout_en = 1'b0;
        sw_clear();
    endtask

    task automatic t_backup();
        on_backup = 1'b1; backup_alarm_en = 1'b0;
        pulse_sec();
        check("R11 suppressed on backup", alarm_flag, 1'b0);
        backup_alarm_en = 1'b1;
        pulse_sec();
        check("R11 allowed on backup", alarm_flag, 1'b1);
        on_backup = 1'b0; backup_alarm_en = 1'b0;
        sw_clear();
    endtask

    task automatic t_priority();
        sec_tick = 1'b1; status_clr = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0; status_clr = 1'b0;
        check("R12 set beats clear", alarm_flag, 1'b1);
        sw_clear();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        rst = 1'b1; sec_tick = 0; ms_tick = 0;
        now_bcd = '0; alm_bcd = '0; field_en = '0;
        alarm_en = 1'b1; pulse_mode = 0; fout_en = 0; auto_clr = 0;
        on_backup = 0; backup_alarm_en = 0; status_rd = 0; status_clr = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_single();
        t_fields();
        t_disabled();
        t_pulse();
        t_autoclr();
        t_fout();
        t_backup();
        t_priority();
        finish_run();
    end
endmodule